// File: doc/BRIEF.md
# Patterned Scaler Pixel-Fetch Sequencer

This block sequences one axis of a nearest-neighbour pixel rescaler. It runs in repeating batches whose length is a programmable kernel width of 1 to 8 iterations. Each iteration emits exactly one output pixel. A per-iteration bitmask chooses what that pixel is. When the bit for the current iteration is set, a fresh pixel is taken from the input stream and emitted. When the bit is clear, the pixel already held is emitted again. The ratio of input pixels to output pixels therefore comes from the number of set bits, not from a fractional step.

The same block serves the vertical and the horizontal axis. Both use valid/ready streams on input and output. The width (coded as width minus one) and the pattern are plain configuration inputs. The block reads them only when a batch starts. An enable input gates the sequencer. Dropping the enable returns the block to the start of a batch with nothing held.

Top module: `scale_fetch_seq`

## Requirements
- R1: The kernel width is given on `cfg_kw_m1` as width minus one (width 1 to 8), and each batch emits exactly that many output pixels.
- R2: Iteration i of a batch (i = 0 is the first) tests `cfg_pattern` bit i, with bit 0 as the LSB. When that bit is set, the iteration accepts one input pixel and emits that same value.
- R3: When the pattern bit for the iteration is clear and a pixel is held, the held pixel is emitted again and no input is accepted for that iteration.
- R4: Pattern bits at indices equal to or above the width have no effect on the output stream.
- R5: The first iteration after reset or after enable returns high has no held pixel, so it accepts an input pixel whatever the pattern says.
- R6: The iteration index wraps to 0 after width minus one. Width and pattern are captured at iteration 0, so a change made in the middle of a batch applies from the next batch.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay unchanged. No input is accepted unless the output register can take the result in the same cycle.
- R8: While `en` is low, `in_ready` is low and no new output is produced. The index returns to 0 and the held pixel is dropped. An output already in the output register is still delivered.
- R9: After synchronous reset, `out_valid` is low, the index is 0 and no pixel is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Sequencer enable; low returns to batch start and drops the held pixel |
| cfg_kw_m1 | input | IDX_W (3) | Kernel width minus one |
| cfg_pattern | input | MAX_K (8) | Fetch bitmask; bit i controls iteration i |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted this cycle when high together with in_valid |
| in_data | input | PIX_W (24) | Input pixel |
| out_valid | output | 1 | Output pixel valid (registered) |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_data | output | PIX_W (24) | Output pixel (registered) |

## Verification
The assertions place no rules on the order in which `in_valid` and `out_ready` arrive, nor on whether they stay stable, so the random stimulus toggles both freely. They do assume the width field holds a legal code. With the default power-of-two depth every 3-bit value is legal. The bench changes width and pattern only in two situations. One is while the block is disabled. The other is in the middle of an 8-wide batch, well away from its boundary. This way its reference model knows which batch picks up each setting. Input pixels carry consecutive values, so any input pixel that is skipped or taken twice shows up as an output mismatch.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  // Action taken by the sequencer in one cycle
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_FETCH = 2'd1,
    ACT_REUSE = 2'd2
  } sfs_act_e;

  // True when the iteration must pull a new input pixel
  function automatic logic needs_fetch(input logic held_vld, input logic pat_bit);
    return !held_vld || pat_bit;
  endfunction

endpackage

// File: rtl/sfs_index.sv
module sfs_index #(
  parameter int MAX_K = 8,
  localparam int IDX_W = (MAX_K > 1) ? $clog2(MAX_K) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             advance,
  input  logic [IDX_W-1:0] cfg_kw,
  input  logic [MAX_K-1:0] cfg_pat,
  output logic [IDX_W-1:0] idx_q,
  output logic [IDX_W-1:0] eff_kw,
  output logic             pat_bit
);

  logic [IDX_W-1:0] kw_q;
  logic [MAX_K-1:0] pat_q;
  logic [MAX_K-1:0] eff_pat;
  logic             at_start;
  logic             at_last;

  // Live configuration at batch start, captured copy afterwards
  always_comb begin
    at_start = (idx_q == '0);
    eff_kw   = at_start ? cfg_kw  : kw_q;
    eff_pat  = at_start ? cfg_pat : pat_q;
    pat_bit  = eff_pat[idx_q];
    at_last  = (idx_q == eff_kw);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      kw_q  <= '0;
      pat_q <= '0;
    end else if (!en) begin
      idx_q <= '0;
    end else if (advance) begin
      if (at_start) begin
        kw_q  <= cfg_kw;
        pat_q <= cfg_pat;
      end
      idx_q <= at_last ? '0 : idx_q + 1'b1;
    end
  end

endmodule

// File: rtl/sfs_decide.sv
module sfs_decide
  import sfs_pkg::*;
(
  input  logic     en,
  input  logic     held_vld,
  input  logic     pat_bit,
  input  logic     out_room,
  input  logic     in_valid,
  output logic     in_ready,
  output sfs_act_e act
);

  logic need;

  always_comb begin
    need     = needs_fetch(held_vld, pat_bit);
    in_ready = en && out_room && need;
    act      = ACT_IDLE;
    if (en && out_room) begin
      if (!need)         act = ACT_REUSE;
      else if (in_valid) act = ACT_FETCH;
    end
  end

endmodule

// File: rtl/sfs_hold.sv
module sfs_hold
  import sfs_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  sfs_act_e         act,
  input  logic [PIX_W-1:0] in_data,
  input  logic             out_ready,
  output logic [PIX_W-1:0] held_q,
  output logic             held_vld,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_data,
  output logic             out_room
);

  assign out_room = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q    <= '0;
      held_vld  <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (!en) held_vld <= 1'b0;
      case (act)
        ACT_FETCH: begin
          held_q    <= in_data;
          held_vld  <= 1'b1;
          out_data  <= in_data;
          out_valid <= 1'b1;
        end
        ACT_REUSE: begin
          out_data  <= held_q;
          out_valid <= 1'b1;
        end
        default: begin
          if (out_ready) out_valid <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/scale_fetch_seq.sv
module scale_fetch_seq
  import sfs_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int MAX_K = 8,
  localparam int IDX_W = (MAX_K > 1) ? $clog2(MAX_K) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [IDX_W-1:0] cfg_kw_m1,
  input  logic [MAX_K-1:0] cfg_pattern,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_data
);

  sfs_act_e         act;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] eff_kw;
  logic             pat_bit;
  logic             held_vld;
  logic [PIX_W-1:0] held_q;
  logic             out_room;
  logic             step;
  logic             in_take;

  assign step    = (act != ACT_IDLE);
  assign in_take = in_valid && in_ready;

  sfs_index #(.MAX_K(MAX_K)) index_i (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .advance (step),
    .cfg_kw  (cfg_kw_m1),
    .cfg_pat (cfg_pattern),
    .idx_q   (idx_q),
    .eff_kw  (eff_kw),
    .pat_bit (pat_bit)
  );

  sfs_decide decide_i (
    .en       (en),
    .held_vld (held_vld),
    .pat_bit  (pat_bit),
    .out_room (out_room),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .act      (act)
  );

  sfs_hold #(.PIX_W(PIX_W)) hold_i (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .act       (act),
    .in_data   (in_data),
    .out_ready (out_ready),
    .held_q    (held_q),
    .held_vld  (held_vld),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_room  (out_room)
  );

endmodule

// File: rtl/sfs_chk.sv
module sfs_chk #(
  parameter int PIX_W = 24,
  parameter int MAX_K = 8,
  localparam int IDX_W = (MAX_K > 1) ? $clog2(MAX_K) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             in_valid,
  input logic             in_ready,
  input logic [PIX_W-1:0] in_data,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_data,
  input logic [IDX_W-1:0] idx_q,
  input logic [IDX_W-1:0] eff_kw,
  input logic             held_vld,
  input logic [PIX_W-1:0] held_q,
  input logic             step,
  input logic             in_take
);

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R7

  AST_DIS_NO_READY: assert property (@(posedge clk) disable iff (rst)
    !en |-> !in_ready); // R8

  AST_DIS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !en |=> (idx_q == '0) && !held_vld); // R8

  AST_IDX_LIMIT: assert property (@(posedge clk) disable iff (rst)
    idx_q <= eff_kw); // R6

  AST_FIRST_TAKE: assert property (@(posedge clk) disable iff (rst)
    step && !held_vld |-> in_take); // R5

  AST_NEW_ON_TAKE: assert property (@(posedge clk) disable iff (rst)
    in_take |=> out_valid && (out_data == $past(in_data))); // R2

  AST_REUSE_HELD: assert property (@(posedge clk) disable iff (rst)
    step && !in_take |=> out_valid && (out_data == $past(held_q))); // R3

endmodule

bind scale_fetch_seq sfs_chk #(.PIX_W(PIX_W), .MAX_K(MAX_K)) chk_i (.*);

// File: tb/scale_fetch_seq_tb_top.sv
module scale_fetch_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W = 24;
  localparam int MAX_K = 8;
  localparam int IDX_W = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             en = 1'b0;
  logic [IDX_W-1:0] cfg_kw_m1 = '0;
  logic [MAX_K-1:0] cfg_pattern = '0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [PIX_W-1:0] in_data = '0;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [PIX_W-1:0] out_data;

  int tests = 0, fails = 0, cycles = 0;
  // knobs set by the stimulus process
  int p_in = 0, p_out = 0, ph_epoch = 0, mdl_epoch = 0;
  bit ph_en = 0, allow_mid = 0;
  logic [IDX_W-1:0] ph_kw = '0;
  logic [MAX_K-1:0] ph_pat = '0;
  // monitor state
  int acc_cnt = 0, m_cnt = 0, m_val = 0, m_pos = 0, seen_mdl = 0, drv_epoch = 0;
  bit m_held = 0, mid_ok = 0;
  logic [IDX_W-1:0] m_kw = '0;
  logic [MAX_K-1:0] m_pat = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scale_fetch_seq #(.PIX_W(PIX_W), .MAX_K(MAX_K)) dut_i (
    .clk(clk), .rst(rst), .en(en), .cfg_kw_m1(cfg_kw_m1), .cfg_pattern(cfg_pattern),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  function automatic bit fetch_now(logic [MAX_K-1:0] pat, int pos, bit held);
    return !held || pat[pos];
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: all inputs change 1 time unit after the rising edge
  always @(posedge clk) begin
    #1;
    if (drv_epoch != ph_epoch) begin
      drv_epoch   = ph_epoch;
      cfg_kw_m1   = ph_kw;
      cfg_pattern = ph_pat;
    end else if (mid_ok && ($urandom % 2 == 0)) begin
      cfg_kw_m1   = IDX_W'($urandom);
      cfg_pattern = MAX_K'($urandom);
    end
    en        = ph_en;
    in_valid  = (int'($urandom % 100) < p_in);
    in_data   = PIX_W'(acc_cnt + 1);
    out_ready = (int'($urandom % 100) < p_out);
  end

  // Monitor and reference model: sampled at the falling edge
  always @(negedge clk) begin
    cycles++;
    mid_ok = 0;
    if (!rst) begin
      if (seen_mdl != mdl_epoch) begin
        seen_mdl = mdl_epoch;
        m_pos = 0;
        m_held = 0;
      end
      if (in_valid && in_ready) acc_cnt++;
      if (out_valid && out_ready) begin
        if (m_pos == 0) begin
          m_kw  = cfg_kw_m1;   // R6: config captured at iteration 0
          m_pat = cfg_pattern;
        end
        if (fetch_now(m_pat, m_pos, m_held)) begin
          m_cnt++;
          m_val = m_cnt;
          m_held = 1;
        end
        // R1 R2 R3 R4 R5 R6: output value follows the batch/pattern model
        check(out_data == PIX_W'(m_val), "R2_R3_R4 output pixel", int'(out_data), m_val);
        mid_ok = allow_mid && (m_kw == 3'd7) && (m_pos == 2);
        m_pos = (m_pos == int'(m_kw)) ? 0 : m_pos + 1;
      end
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic run_phase(int kw, int pat, int n, int pi, int po, bit mid);
    ph_kw = IDX_W'(kw);
    ph_pat = MAX_K'(pat);
    ph_epoch++;
    allow_mid = mid;
    p_in = pi;
    p_out = po;
    ph_en = 1;
    wait_cyc(n);
    // stop and drain the one pending output, then restart the model
    allow_mid = 0;
    ph_en = 0;
    p_in = 0;
    wait_cyc(2);
    p_out = 100;
    wait_cyc(3);
    p_in = 100;
    wait_cyc(2);
    @(negedge clk);
    check(!in_ready, "R8 in_ready while disabled", int'(in_ready), 0);
    check(!out_valid, "R8 no output while disabled", int'(out_valid), 0);
    p_in = 0;
    mdl_epoch++;
    wait_cyc(1);
  endtask

  initial begin
    void'($urandom(32'h1234_abcd));
    wait_cyc(4);
    @(negedge clk);
    check(!out_valid, "R9 out_valid after reset", int'(out_valid), 0);
    check(!in_ready, "R9 in_ready after reset", int'(in_ready), 0);
    rst = 1'b0;
    // R8: input offered while disabled is not taken
    p_in = 100; p_out = 100;
    wait_cyc(4);
    @(negedge clk);
    check(!in_ready, "R8 ignored while disabled", int'(in_ready), 0);
    check(!out_valid, "R8 idle while disabled", int'(out_valid), 0);
    p_in = 0;
    wait_cyc(1);
    run_phase(0, 8'h01, 60, 100, 100, 0);   // R1 R2 pass-through
    run_phase(0, 8'h00, 40, 100, 100, 0);   // R5 R3 one fetch, then repeats
    run_phase(3, 8'hF5, 80, 100, 100, 0);   // R4 upper bits ignored
    run_phase(7, 8'hFF, 60, 80, 90, 0);     // R1 full width
    run_phase(7, 8'h00, 50, 100, 100, 0);   // R5 first fetch only
    run_phase(4, 8'h13, 200, 50, 30, 0);    // R7 backpressure
    run_phase(7, 8'hA5, 400, 70, 70, 1);    // R6 mid-batch changes
    for (int k = 0; k < 40; k++) begin
      int kw = (k % 4 == 0) ? 7 : int'($urandom % 8);
      run_phase(kw, int'($urandom % 256), 100 + int'($urandom % 200),
                20 + int'($urandom % 81), 20 + int'($urandom % 81), 1);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // Watchdog
  always @(posedge clk) begin
    if (cycles > 150000) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule